// File: doc/BRIEF.md
# Dual Interval Timer with Shared Interrupt

This peripheral holds two independent down-counting interval timers behind a 32-bit register bus. Each timer has a reload value, a readable live count and a control word. The control word picks which of four internal tick strobes drives the count, and whether the timer stops after one expiry or reloads and keeps going. Any other clock code leaves the timer frozen, because it stands for an external or disabled clock. Writing the control word reloads the count from the reload value and starts the timer.

An expiry sets a raw interrupt bit for that timer. Software enables the bits it cares about in a mask register, reads the masked status, and clears raw bits by writing ones to an acknowledge register. A single interrupt line is high while any masked bit is set. The tick strobes are one-cycle pulses that the surrounding chip generates from its own clock dividers.

Top module: `dual_interval_timer`

## Requirements
- R1: The reload registers (timer0 at 0x00, timer1 at 0x10) read back the written value. The control registers (0x08, 0x18) read back bits [3:0] of the written value. The mask (0x48) reads back bits [1:0]. The acknowledge address 0x4C, the data addresses when written, and unmapped addresses read 0. Read data appears on `bus_rdata` the cycle after `bus_rd`, and is 0 otherwise.
- R2: A control write loads the count from that timer's reload register. The data register (0x04 for timer0, 0x14 for timer1) returns the count as it stood at the read.
- R3: Control bits [2:0] select the clock: codes 4, 5, 6 and 7 use `tick_src[0]`, `[1]`, `[2]` and `[3]`. Every other code stops counting, and strobes on unselected sources have no effect.
- R4: A running timer decrements by one on each selected tick. The tick that takes it from 1 to 0 is an expiry, and the raw bit (bit 0 for timer0, bit 1 for timer1) is set at that same clock edge.
- R5: With control bit 3 clear (one-shot), a timer stops at 0 after expiry and never expires again until it is reloaded.
- R6: With control bit 3 set (periodic), the count is reloaded from the reload register at the expiry edge, so the timer expires once every reload-value ticks.
- R7: Loading a reload value of 0 leaves the timer stopped at count 0, and it never expires.
- R8: A write to 0x4C clears every raw bit whose position is set in the written value. A raw bit that expires in the same cycle as its acknowledge stays set.
- R9: The status register at 0x54 reads the raw bits ANDed with the mask.
- R10: `irq` is high exactly when the raw bits ANDed with the mask are nonzero, and it changes at the same edge as the bits do.
- R11: Synchronous reset clears the counts, reload values, control words, mask and raw bits, stops both timers and drives `irq` low.
- R12: A control write in the same cycle as a selected tick performs the reload only: no decrement and no expiry in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_rd | input | 1 | Read strobe for one cycle |
| bus_addr | input | ADDR_W | Byte address within the register window |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data, valid the cycle after `bus_rd` |
| tick_src | input | 4 | Internal tick strobes selected by clock codes 4 to 7 |
| irq | output | 1 | Shared interrupt, high while any masked raw bit is set |

## Verification
The hardest case to reach is an expiry and an acknowledge of the same raw bit landing on one clock edge, because the expiry depends on the count and on a tick arriving. The stimulus sets a periodic reload of 1 so that every selected tick is an expiry. It then drives that tick strobe in the same cycle as the acknowledge write and reads the status back. The same cycle-alignment trick places a control write on a tick edge. A long randomized phase with small reload values then mixes writes, reads and ticks so that these collisions also occur by chance, against a behavioural reference model.

// File: rtl/dit_pkg.sv
package dit_pkg;
  localparam int unsigned NUM_TMR    = 2;
  localparam int unsigned NUM_SRC    = 4;
  localparam int unsigned TMR_STRIDE = 'h10;
  localparam int unsigned OFF_DIV    = 'h00;
  localparam int unsigned OFF_DATA   = 'h04;
  localparam int unsigned OFF_CTRL   = 'h08;
  localparam int unsigned OFF_MASK   = 'h48;
  localparam int unsigned OFF_ACK    = 'h4C;
  localparam int unsigned OFF_STAT   = 'h54;

  typedef struct packed {
    logic       periodic;
    logic [2:0] sel;
  } tmr_ctrl_t;

  localparam int unsigned CTRL_W = $bits(tmr_ctrl_t);
endpackage

// File: rtl/dit_timer.sv
module dit_timer
  import dit_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  tmr_ctrl_t            ctrl,
  input  logic [CNT_W-1:0]     reload,
  input  logic                 load,
  input  logic [NUM_SRC-1:0]   tick_src,
  output logic [CNT_W-1:0]     count,
  output logic                 running,
  output logic                 expire
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             run_q;
  logic             tick;

  // Codes with the top bit set pick an internal strobe; all others freeze.
  always_comb begin
    tick = 1'b0;
    if (ctrl.sel[2]) tick = tick_src[ctrl.sel[1:0]];
  end

  assign expire = run_q && tick && (cnt_q == ONE) && !load;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (load) begin
      cnt_q <= reload;
      run_q <= (reload != '0);
    end else if (run_q && tick) begin
      if (cnt_q == ONE) begin
        if (ctrl.periodic) begin
          cnt_q <= reload;
          run_q <= (reload != '0);
        end else begin
          cnt_q <= '0;
          run_q <= 1'b0;
        end
      end else begin
        cnt_q <= cnt_q - ONE;
      end
    end
  end

  assign count   = cnt_q;
  assign running = run_q;
endmodule

// File: rtl/dit_irq.sv
module dit_irq
  import dit_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_TMR-1:0] expire,
  input  logic               ack_wr,
  input  logic               mask_wr,
  input  logic [NUM_TMR-1:0] wbits,
  output logic [NUM_TMR-1:0] raw,
  output logic [NUM_TMR-1:0] mask,
  output logic               irq
);
  logic [NUM_TMR-1:0] raw_q, raw_d;
  logic [NUM_TMR-1:0] mask_q, mask_d;
  logic               irq_q;

  // Expiry is OR-ed in after the clear so a same-cycle expiry wins.
  always_comb begin
    raw_d  = (raw_q & ~(ack_wr ? wbits : '0)) | expire;
    mask_d = mask_wr ? wbits : mask_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      raw_q  <= '0;
      mask_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      raw_q  <= raw_d;
      mask_q <= mask_d;
      irq_q  <= |(raw_d & mask_d);
    end
  end

  assign raw  = raw_q;
  assign mask = mask_q;
  assign irq  = irq_q;
endmodule

// File: rtl/dit_regfile.sv
module dit_regfile
  import dit_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 32
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            bus_wr,
  input  logic                            bus_rd,
  input  logic [ADDR_W-1:0]               bus_addr,
  input  logic [DATA_W-1:0]               bus_wdata,
  input  logic [NUM_TMR-1:0][CNT_W-1:0]   tmr_cnt,
  input  logic [NUM_TMR-1:0]              irq_raw,
  input  logic [NUM_TMR-1:0]              irq_mask,
  output logic [NUM_TMR-1:0][CNT_W-1:0]   tmr_div,
  output tmr_ctrl_t [NUM_TMR-1:0]         tmr_ctrl,
  output logic [NUM_TMR-1:0]              tmr_load,
  output logic                            mask_wr,
  output logic                            ack_wr,
  output logic [DATA_W-1:0]               bus_rdata
);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(OFF_MASK);
  localparam logic [ADDR_W-1:0] A_ACK  = ADDR_W'(OFF_ACK);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STAT);

  logic [DATA_W-1:0] rd_mux;

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr_regs
    localparam logic [ADDR_W-1:0] A_DIV  = ADDR_W'(TMR_STRIDE * i + OFF_DIV);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(TMR_STRIDE * i + OFF_CTRL);

    logic div_hit, ctrl_hit;
    assign div_hit  = bus_wr && (bus_addr == A_DIV);
    assign ctrl_hit = bus_wr && (bus_addr == A_CTRL);
    assign tmr_load[i] = ctrl_hit;

    always_ff @(posedge clk) begin
      if (rst) begin
        tmr_div[i]  <= '0;
        tmr_ctrl[i] <= '0;
      end else begin
        if (div_hit)  tmr_div[i]  <= bus_wdata[CNT_W-1:0];
        if (ctrl_hit) tmr_ctrl[i] <= tmr_ctrl_t'(bus_wdata[CTRL_W-1:0]);
      end
    end
  end

  assign mask_wr = bus_wr && (bus_addr == A_MASK);
  assign ack_wr  = bus_wr && (bus_addr == A_ACK);

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NUM_TMR; i++) begin
      if (bus_addr == ADDR_W'(TMR_STRIDE * i + OFF_DIV))  rd_mux = DATA_W'(tmr_div[i]);
      if (bus_addr == ADDR_W'(TMR_STRIDE * i + OFF_DATA)) rd_mux = DATA_W'(tmr_cnt[i]);
      if (bus_addr == ADDR_W'(TMR_STRIDE * i + OFF_CTRL)) rd_mux = DATA_W'(tmr_ctrl[i]);
    end
    if (bus_addr == A_MASK) rd_mux = DATA_W'(irq_mask);
    if (bus_addr == A_STAT) rd_mux = DATA_W'(irq_raw & irq_mask);
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
    else             bus_rdata <= '0;
  end
endmodule

// File: rtl/dual_interval_timer.sv
module dual_interval_timer
  import dit_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [3:0]        tick_src,
  output logic              irq
);
  logic [NUM_TMR-1:0][CNT_W-1:0] tmr_cnt;
  logic [NUM_TMR-1:0][CNT_W-1:0] tmr_div;
  tmr_ctrl_t [NUM_TMR-1:0]       tmr_ctrl;
  logic [NUM_TMR-1:0]            tmr_load;
  logic [NUM_TMR-1:0]            tmr_run;
  logic [NUM_TMR-1:0]            tmr_exp;
  logic [NUM_TMR-1:0]            tmr_per;
  logic [NUM_TMR-1:0]            irq_raw;
  logic [NUM_TMR-1:0]            irq_mask;
  logic                          mask_wr;
  logic                          ack_wr;

  dit_regfile #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
  ) u_regs (
    .clk(clk), .rst(rst),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .tmr_cnt(tmr_cnt), .irq_raw(irq_raw), .irq_mask(irq_mask),
    .tmr_div(tmr_div), .tmr_ctrl(tmr_ctrl), .tmr_load(tmr_load),
    .mask_wr(mask_wr), .ack_wr(ack_wr), .bus_rdata(bus_rdata)
  );

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
    dit_timer #(.CNT_W(CNT_W)) u_tmr (
      .clk(clk), .rst(rst),
      .ctrl(tmr_ctrl[i]), .reload(tmr_div[i]), .load(tmr_load[i]),
      .tick_src(tick_src),
      .count(tmr_cnt[i]), .running(tmr_run[i]), .expire(tmr_exp[i])
    );
    assign tmr_per[i] = tmr_ctrl[i].periodic;
  end

  dit_irq u_irq (
    .clk(clk), .rst(rst),
    .expire(tmr_exp), .ack_wr(ack_wr), .mask_wr(mask_wr),
    .wbits(bus_wdata[NUM_TMR-1:0]),
    .raw(irq_raw), .mask(irq_mask), .irq(irq)
  );
endmodule

// File: rtl/dit_checker.sv
module dit_checker
  import dit_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 32
) (
  input logic                          clk,
  input logic                          rst,
  input logic                          bus_wr,
  input logic                          bus_rd,
  input logic [ADDR_W-1:0]             bus_addr,
  input logic [NUM_TMR-1:0]            ack_bits,
  input logic [DATA_W-1:0]             bus_rdata,
  input logic                          irq,
  input logic [NUM_TMR-1:0][CNT_W-1:0] tmr_cnt,
  input logic [NUM_TMR-1:0][CNT_W-1:0] tmr_div,
  input logic [NUM_TMR-1:0]            tmr_run,
  input logic [NUM_TMR-1:0]            tmr_exp,
  input logic [NUM_TMR-1:0]            tmr_per,
  input logic [NUM_TMR-1:0]            irq_raw,
  input logic [NUM_TMR-1:0]            irq_mask
);
  localparam logic [ADDR_W-1:0] A_ACK  = ADDR_W'(OFF_ACK);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STAT);

  AST_IRQ_FOLLOWS_MASKED: assert property (@(posedge clk) disable iff (rst)
    irq == |(irq_raw & irq_mask)); // R10

  AST_STATUS_READBACK: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == A_STAT) |=> bus_rdata == DATA_W'($past(irq_raw & irq_mask))); // R9

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!irq && irq_raw == '0 && tmr_run == '0)); // R11

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_chk
    AST_EXPIRY_SETS_RAW: assert property (@(posedge clk) disable iff (rst)
      tmr_exp[i] |=> irq_raw[i]); // R4

    AST_ONESHOT_HALTS: assert property (@(posedge clk) disable iff (rst)
      (tmr_exp[i] && !tmr_per[i]) |=> (!tmr_run[i] && tmr_cnt[i] == '0)); // R5

    AST_PERIODIC_RELOADS: assert property (@(posedge clk) disable iff (rst)
      (tmr_exp[i] && tmr_per[i]) |=> tmr_cnt[i] == $past(tmr_div[i])); // R6

    AST_ACK_CLEARS_BIT: assert property (@(posedge clk) disable iff (rst)
      (bus_wr && bus_addr == A_ACK && ack_bits[i] && !tmr_exp[i]) |=> !irq_raw[i]); // R8

    AST_ACK_LOSES_TO_EXPIRY: assert property (@(posedge clk) disable iff (rst)
      (bus_wr && bus_addr == A_ACK && ack_bits[i] && tmr_exp[i]) |=> irq_raw[i]); // R8
  end
endmodule

bind dual_interval_timer dit_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .ack_bits(bus_wdata[1:0]), .bus_rdata(bus_rdata), .irq(irq),
  .tmr_cnt(tmr_cnt), .tmr_div(tmr_div), .tmr_run(tmr_run), .tmr_exp(tmr_exp),
  .tmr_per(tmr_per), .irq_raw(irq_raw), .irq_mask(irq_mask)
);

// File: tb/dual_interval_timer_tb.sv
`timescale 1ns/1ps
module dual_interval_timer_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  tick_src = '0;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  bit started = 0;

  always #2.5 clk = ~clk;

  dual_interval_timer u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_src(tick_src), .irq(irq)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  bit [31:0] m_div [2];
  bit [3:0]  m_ctl [2];
  bit [31:0] m_cnt [2];
  bit        m_run [2];
  bit [1:0]  m_raw, m_mask;
  bit        m_irq;
  bit        m_rpend;
  bit [31:0] m_rexp;
  bit [7:0]  m_raddr;

  function automatic bit [31:0] model_read(input bit [7:0] a);
    case (a)
      8'h00: return m_div[0];
      8'h04: return m_cnt[0];
      8'h08: return 32'(m_ctl[0]);
      8'h10: return m_div[1];
      8'h14: return m_cnt[1];
      8'h18: return 32'(m_ctl[1]);
      8'h48: return 32'(m_mask);
      8'h54: return 32'(m_raw & m_mask);
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_of(input bit [7:0] a);
    if (a == 8'h04 || a == 8'h14) return "R2";
    if (a == 8'h54) return "R9";
    return "R1";
  endfunction

  always @(posedge clk) begin
    started = 1;
    if (rst) begin
      for (int t = 0; t < 2; t++) begin
        m_div[t] = 0; m_ctl[t] = 0; m_cnt[t] = 0; m_run[t] = 0;
      end
      m_raw = 0; m_mask = 0; m_irq = 0; m_rpend = 0;
    end else begin
      bit [1:0] ex;
      m_rpend = bus_rd;
      if (bus_rd) begin
        m_rexp  = model_read(bus_addr);
        m_raddr = bus_addr;
      end
      ex = 0;
      for (int t = 0; t < 2; t++) begin
        bit tk;
        bit ld;
        tk = m_ctl[t][2] ? tick_src[m_ctl[t][1:0]] : 1'b0;
        ld = bus_wr && (bus_addr == 8'(16 * t + 8));
        if (ld) begin
          m_cnt[t] = m_div[t];
          m_run[t] = (m_div[t] != 0);
        end else if (m_run[t] && tk) begin
          if (m_cnt[t] == 1) begin
            ex[t] = 1'b1;
            if (m_ctl[t][3]) begin
              m_cnt[t] = m_div[t];
              m_run[t] = (m_div[t] != 0);
            end else begin
              m_cnt[t] = 0;
              m_run[t] = 0;
            end
          end else begin
            m_cnt[t] = m_cnt[t] - 1;
          end
        end
      end
      if (bus_wr && bus_addr == 8'h4C) m_raw = m_raw & ~bus_wdata[1:0];
      m_raw = m_raw | ex;
      if (bus_wr) begin
        case (bus_addr)
          8'h00: m_div[0] = bus_wdata;
          8'h10: m_div[1] = bus_wdata;
          8'h08: m_ctl[0] = bus_wdata[3:0];
          8'h18: m_ctl[1] = bus_wdata[3:0];
          8'h48: m_mask   = bus_wdata[1:0];
          default: ;
        endcase
      end
      m_irq = (m_raw & m_mask) != 0;
    end
  end

  // Compare against the model on every clock, away from the active edge
  always @(negedge clk) begin
    if (started) begin
      chk(irq == m_irq, "R10 irq vs model", 32'(irq), 32'(m_irq));
      if (m_rpend) chk(bus_rdata == m_rexp, tag_of(m_raddr), bus_rdata, m_rexp);
      else chk(bus_rdata == 0, "R1 idle rdata", bus_rdata, 0);
    end
  end

  task automatic wr(input bit [7:0] a, input bit [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic wr_tick(input bit [7:0] a, input bit [31:0] d, input bit [3:0] tk);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d; tick_src = tk;
    @(negedge clk); bus_wr = 0; tick_src = 0;
  endtask

  task automatic rd_expect(input bit [7:0] a, input bit [31:0] e, input string tag);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    @(negedge clk); bus_rd = 0;
    chk(bus_rdata == e, tag, bus_rdata, e);
  endtask

  task automatic tick(input int n, input bit [3:0] tk);
    repeat (n) begin
      @(negedge clk); tick_src = tk;
      @(negedge clk); tick_src = 0;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    // R11 reset state
    chk(irq == 0, "R11 irq after reset", 32'(irq), 0);
    rd_expect(8'h00, 0, "R11 div0");
    rd_expect(8'h04, 0, "R11 cnt0");
    rd_expect(8'h08, 0, "R11 ctl0");
    rd_expect(8'h14, 0, "R11 cnt1");
    rd_expect(8'h48, 0, "R11 mask");
    rd_expect(8'h54, 0, "R11 status");
    // R1 register readback
    wr(8'h00, 5);            rd_expect(8'h00, 5, "R1 div0");
    wr(8'h10, 32'hABCD);     rd_expect(8'h10, 32'hABCD, "R1 div1");
    wr(8'h48, 32'hFFFFFFFF); rd_expect(8'h48, 3, "R1 mask width");
    wr(8'h48, 0);
    rd_expect(8'h4C, 0, "R1 ack reads zero");
    rd_expect(8'h30, 0, "R1 unmapped");
    wr(8'h04, 32'h77);       rd_expect(8'h04, 0, "R1 data write ignored");
    wr(8'h18, 32'hF3);       rd_expect(8'h18, 3, "R1 ctrl low bits");
    // R3 code 3 does not count
    tick(4, 4'hF);
    rd_expect(8'h14, 32'hABCD, "R3 external code frozen");
    // R2/R4/R5 one-shot on source 0
    wr(8'h00, 3); wr(8'h48, 1); wr(8'h08, 4);
    rd_expect(8'h04, 3, "R2 load from reload");
    tick(1, 4'b0010);
    rd_expect(8'h04, 3, "R3 unselected source");
    tick(2, 4'b0001);
    rd_expect(8'h04, 1, "R4 decrement");
    chk(irq == 0, "R4 no early expiry", 32'(irq), 0);
    tick(1, 4'b0001);
    chk(irq == 1, "R4 expiry raises irq", 32'(irq), 1);
    rd_expect(8'h04, 0, "R4 count at zero");
    rd_expect(8'h54, 1, "R9 status bit0");
    wr(8'h4C, 1);
    chk(irq == 0, "R8 ack lowers irq", 32'(irq), 0);
    tick(3, 4'b0001);
    rd_expect(8'h04, 0, "R5 one-shot stays");
    rd_expect(8'h54, 0, "R5 no re-expiry");
    // R6 periodic on source 2
    wr(8'h10, 2); wr(8'h48, 2); wr(8'h18, 32'hE);
    tick(2, 4'b0100);
    rd_expect(8'h14, 2, "R6 reload at expiry");
    rd_expect(8'h54, 2, "R6 status bit1");
    wr(8'h4C, 2);
    tick(2, 4'b0100);
    rd_expect(8'h54, 2, "R6 second period");
    wr(8'h4C, 2);
    // R8 collision of expiry and acknowledge
    wr(8'h00, 1); wr(8'h48, 3); wr(8'h08, 32'hD);
    tick(1, 4'b0010);
    rd_expect(8'h54, 1, "R8 setup raw0");
    wr_tick(8'h4C, 1, 4'b0010);
    rd_expect(8'h54, 1, "R8 expiry beats ack");
    wr(8'h4C, 1);
    rd_expect(8'h54, 0, "R8 plain ack clears");
    // R12 control write with a tick
    wr(8'h00, 3); wr(8'h08, 4);
    tick(1, 4'b0001);
    rd_expect(8'h04, 2, "R12 setup");
    wr_tick(8'h08, 4, 4'b0001);
    rd_expect(8'h04, 3, "R12 reload wins over tick");
    // R7 zero reload
    wr(8'h00, 0); wr(8'h08, 32'hC);
    tick(5, 4'b0001);
    rd_expect(8'h04, 0, "R7 zero reload idle");
    rd_expect(8'h54, 0, "R7 no expiry");
    // R11 reset during activity
    tick(2, 4'b0100);
    chk(irq == 1, "R11 setup irq", 32'(irq), 1);
    @(negedge clk); rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
    chk(irq == 0, "R11 irq cleared", 32'(irq), 0);
    rd_expect(8'h14, 0, "R11 count cleared");
    rd_expect(8'h48, 0, "R11 mask cleared");
    // Randomized soak against the model
    for (int k = 0; k < 4000; k++) begin
      bit [7:0] offs [9];
      int op;
      offs = '{8'h00, 8'h04, 8'h08, 8'h10, 8'h14, 8'h18, 8'h48, 8'h4C, 8'h54};
      @(negedge clk);
      op = $urandom_range(0, 9);
      bus_wr = 0; bus_rd = 0;
      bus_addr = offs[$urandom_range(0, 8)];
      bus_wdata = (bus_addr == 8'h00 || bus_addr == 8'h10) ? $urandom_range(0, 5) : $urandom;
      if (op < 2) bus_wr = 1;
      else if (op < 5) bus_rd = 1;
      tick_src = 4'($urandom);
    end
    @(negedge clk); bus_wr = 0; bus_rd = 0; tick_src = 0;
    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule